// File: doc/BRIEF.md
# Register Field Access-Mode Cell

This block holds one bit field of a control/status register and gives it one of ten access behaviours, chosen by a parameter when the field is built. The bus side is reduced to a read strobe, a write strobe and write data, with a second write vector used only by the combined set/clear mode. The peripheral side offers per-bit set and clear request vectors for the flag modes, a data input that read-only fields present to the bus, and a data output that carries the stored value into the peripheral's logic. Address decoding and splitting a register into bus-width pieces happen elsewhere. One cell is built per field, and the register mux packs the `bus_rdata` of several cells together.

The basic modes give the value a single writer: the peripheral for read-only, the bus for write-only and read/write. The flag modes let the bus and the peripheral act on the same bits in the same cycle, each bit on its own. Fixed priorities decide the outcome when both act on one bit. The combined set/clear mode takes a set mask and a clear mask in one bus write, so several bits can change atomically with no read-modify-write. The four reserved modes hold no storage, read as zero and ignore writes, so software that follows the rules for a placeholder (writing back what it read, or writing zero) stays harmless.

Read data is registered. A read strobe in cycle n puts the field's view, taken before any write in that same cycle, on `bus_rdata` in cycle n+1. In every other cycle `bus_rdata` is zero, so the outputs of several cells can be ORed together.

Top module: `csr_field_cell`

## Requirements
- R1: Synchronous active-high reset loads the stored value with parameter INIT, so `per_dout` equals INIT in the storing modes, and drives `bus_rdata` to zero.
- R2: `bus_rdata` is registered. After a cycle with `bus_rd` high it shows the mode's read view as it stood before that cycle's update, and after a cycle with `bus_rd` low it is zero.
- R3: In read-only mode (MODE value 0) the read view is `per_din` as sampled in the read cycle. Bus writes have no effect, and `per_dout` is zero.
- R4: In write-only (1) and read/write (2) modes a bus write stores `bus_wdata`, which appears on `per_dout` the next cycle. Write-only reads return zero, and read/write reads return the stored value. Peripheral inputs have no effect.
- R5: In write-1-to-clear mode (3) a bus write clears each bit written as 1 and keeps each bit written as 0. `per_set` sets bits and `per_clr` clears them. If `per_set` and any clear hit the same bit in the same cycle, the bit ends up set.
- R6: In write-1-to-set mode (4) a bus write sets each bit written as 1. `per_set` sets bits and `per_clr` clears them. If a bus set and `per_clr` hit the same bit in the same cycle, the bit ends up set.
- R7: In combined set/clear mode (5) a bus write sets the bits that are 1 in `bus_wdata` and clears the bits that are 1 in `bus_wclr`. A bus set beats any clear on the same bit. `per_set` and `per_clr` act as in R6.
- R8: Every flag bit follows its own request bits only. With no request on a bit, that bit keeps its value.
- R9: The reserved modes (6 read-any/write-zero, 7 read-any/write-last, 8 read-zero/write-any, 9 read-zero/write-zero) read as zero, drive `per_dout` to zero and are unchanged by any write. Writing back the last value read therefore preserves them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | W | Bus write data; the set mask in set/clear mode |
| bus_wclr | input | W | Clear mask, used only in set/clear mode |
| bus_rdata | output | W | Registered read data, zero when no read was made |
| per_set | input | W | Peripheral per-bit set requests (flag modes) |
| per_clr | input | W | Peripheral per-bit clear requests (flag modes) |
| per_din | input | W | Peripheral value for read-only mode |
| per_dout | output | W | Stored value presented to the peripheral |

## Verification
Every cycle, the assertions check the priority rule in the flag store: a winning set always lands and an unopposed clear always clears. They also check that an idle flag keeps its value, that a write in the basic modes stores its data, that `bus_rdata` is zero after a cycle with no read and that reserved fields stay zero. Other behaviour depends on the mode and has to be compared against a model, so only the bench scenarios show it. This covers the exact write-1-to-clear and write-1-to-set outcomes when both sides change mixed bits at once, the fact that a read returns the value from before that cycle's write, and the atomic set-plus-clear write. The bench drives all ten modes in parallel with one shared random stimulus and adds directed same-bit collisions.

// File: rtl/csr_cell_pkg.sv
package csr_cell_pkg;

  typedef enum logic [3:0] {
    CM_RO           = 4'd0,
    CM_WO           = 4'd1,
    CM_RW           = 4'd2,
    CM_W1C          = 4'd3,
    CM_W1S          = 4'd4,
    CM_SETCLR       = 4'd5,
    CM_RSV_ANY0     = 4'd6,
    CM_RSV_ANYLAST  = 4'd7,
    CM_RSV_ZEROANY  = 4'd8,
    CM_RSV_ZEROZERO = 4'd9
  } cell_mode_e;

  localparam int NUM_MODES = 10;

  function automatic logic is_flag(cell_mode_e m);
    return (m == CM_W1C) || (m == CM_W1S) || (m == CM_SETCLR);
  endfunction

  function automatic logic is_basic_store(cell_mode_e m);
    return (m == CM_WO) || (m == CM_RW);
  endfunction

endpackage

// File: rtl/csr_basic_store.sv
module csr_basic_store #(
  parameter int         W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= INIT;
    else if (wr_en) q <= wdata;
  end

  AST_BASIC_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == INIT); // R1
  AST_BASIC_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> q == $past(wdata)); // R4
  AST_BASIC_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q)); // R4

endmodule

// File: rtl/csr_flag_store.sv
module csr_flag_store #(
  parameter int         W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lo_set,   // weakest set request
  input  logic [W-1:0] clr,      // clears, beaten by hi_set only
  input  logic [W-1:0] hi_set,   // winning set request
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  // Each bit resolves independently: weak set, then clear, then strong set.
  always_comb nxt = ((q | lo_set) & ~clr) | hi_set;

  always_ff @(posedge clk) begin
    if (rst) q <= INIT;
    else     q <= nxt;
  end

  AST_FLAG_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == INIT); // R1
  AST_FLAG_STRONG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|hi_set) |=> ((q & $past(hi_set)) == $past(hi_set))); // R5
  AST_FLAG_CLEAR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (|clr) |=> ((q & $past(clr & ~hi_set)) == '0)); // R6
  AST_FLAG_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(|lo_set) && !(|clr) && !(|hi_set)) |=> $stable(q)); // R8

endmodule

// File: rtl/csr_read_port.sv
module csr_read_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic [W-1:0] view,
  output logic [W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= view;
    else         rdata <= '0;
  end

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0); // R2
  AST_RDATA_CAPTURES_VIEW: assert property (@(posedge clk) disable iff (rst)
    rd |=> rdata == $past(view)); // R2

endmodule

// File: rtl/csr_field_cell.sv
module csr_field_cell
  import csr_cell_pkg::*;
#(
  parameter int           W    = 8,
  parameter cell_mode_e   MODE = CM_RW,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] bus_wclr,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] per_set,
  input  logic [W-1:0] per_clr,
  input  logic [W-1:0] per_din,
  output logic [W-1:0] per_dout
);

  logic [W-1:0] view;
  logic [W-1:0] store_q;
  logic         unused_inputs;

  // Not every mode reads every input.
  assign unused_inputs = ^{bus_wclr, per_din, per_set, per_clr, bus_wdata, bus_wr};

  generate
    if (MODE == CM_RO) begin : g_ro
      assign view    = per_din;
      assign store_q = '0;

      AST_RO_READS_PERIPHERAL: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rdata == $past(per_din)); // R3
      AST_RO_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> per_dout == '0); // R3
    end else if (is_basic_store(MODE)) begin : g_basic
      csr_basic_store #(.W(W), .INIT(INIT)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .wdata (bus_wdata),
        .q     (store_q)
      );
      assign view = (MODE == CM_RW) ? store_q : '0;
    end else if (is_flag(MODE)) begin : g_flag
      logic [W-1:0] bus_ones;
      logic [W-1:0] bus_clrm;
      logic [W-1:0] lo_set, clr, hi_set;

      assign bus_ones = bus_wr ? bus_wdata : '0;
      assign bus_clrm = bus_wr ? bus_wclr  : '0;

      if (MODE == CM_W1C) begin : g_w1c
        // peripheral set beats every clear so no event is lost
        assign lo_set = '0;
        assign clr    = per_clr | bus_ones;
        assign hi_set = per_set;
      end else if (MODE == CM_W1S) begin : g_w1s
        // bus set beats the peripheral's clear
        assign lo_set = per_set;
        assign clr    = per_clr;
        assign hi_set = bus_ones;
      end else begin : g_setclr
        // one write carries a set mask and a clear mask; set wins
        assign lo_set = per_set;
        assign clr    = per_clr | bus_clrm;
        assign hi_set = bus_ones;
      end

      csr_flag_store #(.W(W), .INIT(INIT)) u_store (
        .clk    (clk),
        .rst    (rst),
        .lo_set (lo_set),
        .clr    (clr),
        .hi_set (hi_set),
        .q      (store_q)
      );
      assign view = store_q;
    end else begin : g_rsv
      assign view    = '0;
      assign store_q = '0;

      AST_RSV_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (bus_rdata == '0) && (per_dout == '0)); // R9
    end
  endgenerate

  assign per_dout = store_q;

  csr_read_port #(.W(W)) u_rport (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .view  (view),
    .rdata (bus_rdata)
  );

endmodule

// File: tb/csr_field_cell_test.sv
`timescale 1ns/1ps
module csr_field_cell_test;
  import csr_cell_pkg::*;

  localparam int W = 8;
  localparam logic [W-1:0] INIT = 8'hA5;
  localparam int NM = NUM_MODES;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_rd = 1'b0, bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0, bus_wclr = '0;
  logic [W-1:0] per_set = '0, per_clr = '0, per_din = '0;
  logic [W-1:0] rdata_a [NM];
  logic [W-1:0] dout_a  [NM];

  logic [W-1:0] mq     [NM];
  logic [W-1:0] exp_r  [NM];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NM; g++) begin : g_mode
    csr_field_cell #(.W(W), .MODE(cell_mode_e'(g)), .INIT(INIT)) uut (
      .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_wclr(bus_wclr), .bus_rdata(rdata_a[g]),
      .per_set(per_set), .per_clr(per_clr), .per_din(per_din),
      .per_dout(dout_a[g])
    );
  end

  function automatic string req_of(int m);
    case (m)
      0:       return "R3";
      1, 2:    return "R4";
      3:       return "R5";
      4:       return "R6";
      5:       return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [W-1:0] model_next(int m, logic [W-1:0] q, logic wr,
      logic [W-1:0] wd, logic [W-1:0] wc, logic [W-1:0] ps, logic [W-1:0] pc);
    logic [W-1:0] b = wr ? wd : '0;
    logic [W-1:0] c = wr ? wc : '0;
    case (m)
      1, 2:    return wr ? wd : q;
      3:       return (q & ~pc & ~b) | ps;
      4:       return ((q | ps) & ~pc) | b;
      5:       return ((q | ps) & ~pc & ~c) | b;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] model_view(int m, logic [W-1:0] q, logic [W-1:0] din);
    case (m)
      0:          return din;
      2, 3, 4, 5: return q;
      default:    return '0;
    endcase
  endfunction

  task automatic check(string tag, int m, logic [W-1:0] act, logic [W-1:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode %0d %s: actual %h expected %h", tag, m, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int m = 0; m < NM; m++) begin
      check(tag, m, rdata_a[m], exp_r[m], "bus_rdata");
      check(tag, m, dout_a[m], mq[m], "per_dout");
    end
  endtask

  // One bus/peripheral cycle, then compare every mode against its model.
  task automatic step(string tag, logic rd, logic wr, logic [W-1:0] wd,
      logic [W-1:0] wc, logic [W-1:0] ps, logic [W-1:0] pc, logic [W-1:0] di);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_wdata = wd; bus_wclr = wc;
    per_set = ps; per_clr = pc; per_din = di;
    for (int m = 0; m < NM; m++) begin
      exp_r[m] = rd ? model_view(m, mq[m], di) : '0;
      mq[m]    = model_next(m, mq[m], wr, wd, wc, ps, pc);
    end
    @(posedge clk); #1;
    for (int m = 0; m < NM; m++) begin
      check($sformatf("%s%s", tag, req_of(m)), m, rdata_a[m], exp_r[m], "bus_rdata");
      check($sformatf("%s%s", tag, req_of(m)), m, dout_a[m], mq[m], "per_dout");
    end
  endtask

  initial begin : watchdog
    #(5ns * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    // R1: reset, with a write pending that must not win
    rst = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    for (int m = 0; m < NM; m++) begin
      mq[m]    = (m == 0 || m >= 6) ? '0 : INIT;
      exp_r[m] = '0;
    end
    check_all("R1 ");
    @(negedge clk); rst = 1'b0; bus_wr = 1'b0;

    // R2: read returns the value from before the same-cycle write
    step("R2 ", 1'b1, 1'b1, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h96);
    step("R2 ", 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11);
    // R5/R6/R7: same-bit collisions
    step("R5 ", 1'b0, 1'b1, 8'hFF, 8'hFF, 8'h81, 8'h00, 8'h00);
    step("R6 ", 1'b1, 1'b1, 8'h0F, 8'h00, 8'h00, 8'hFF, 8'h00);
    step("R7 ", 1'b1, 1'b1, 8'hC3, 8'h3C, 8'h00, 8'h00, 8'h00);
    step("R7 ", 1'b1, 1'b1, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00);
    // R9: write-back of read value and write of zero leave reserved fields at zero
    step("R9 ", 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step("R9 ", 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF);
    // R3/R4: peripheral inputs ignored by basic modes, bus ignored by read-only
    step("R3 ", 1'b1, 1'b0, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h5A);

    // R8: random mixes of bus and peripheral requests, sparse bit patterns
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ps = $urandom() & $urandom();
      logic [W-1:0] pc = $urandom() & $urandom();
      step("R8 ", 1'($urandom()), 1'($urandom_range(0, 3) == 0), W'($urandom()),
           W'($urandom()), ps, pc, W'($urandom()));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule